// File: doc/BRIEF.md
# Bidirectional Bit Scan Unit

This block finds the first set bit in an operand and reports where it is. It can scan from the least significant end, which gives the lowest set bit, or from the most significant end, which gives the highest set bit. In both directions the reported position counts from bit 0 at the least significant end. A size select chooses between the full 32-bit operand and its low 16 bits. When the narrow size is chosen, the upper operand bits play no part in the scan.

If the scanned bits contain at least one 1, the unit drives the position onto the destination output, zero-extended to the full width. It also raises a write-enable and clears the zero flag. If every scanned bit is 0, the zero flag is raised, the write-enable stays low, and the destination output repeats the previous destination value supplied by the caller. That way a downstream register file sees no change. The zero flag is the only status bit the unit defines.

Both directions share one priority finder. A reverse scan mirrors the masked operand before the finder and mirrors the index after it. With the default setting the result is registered, so it appears one clock after the input is presented.

Top module: `bit_scan_unit`

## Requirements
- R1: With scan_rev = 0 and a nonzero scanned operand, dest is the index of the lowest set bit.
- R2: With scan_rev = 1 and a nonzero scanned operand, dest is the index of the highest set bit.
- R3: zero_flag is 1 exactly when every scanned operand bit is 0, and 0 otherwise.
- R4: When the scanned bits are all 0, dest equals the prev_dest value presented with that input and dest_we is 0.
- R5: When a set bit is found, dest_we is 1. dest_we is always the inverse of zero_flag while out_valid is 1.
- R6: With size_wide = 0 only operand[15:0] is scanned. Bits 31:16 have no effect on dest or zero_flag. With size_wide = 1 all 32 bits are scanned.
- R7: A found index is zero-extended: dest bits above bit 4 are 0.
- R8: Outputs reflect the input sampled on the previous rising clock edge, and out_valid equals in_valid delayed by one cycle.
- R9: While rst is high, and on the cycle after it, out_valid, dest_we and zero_flag are 0 and dest is 0.
- R10: Positions count from bit 0 at the least significant end in both scan directions, so a lone bit k gives k whichever direction is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input fields carry a scan request |
| operand | input | 32 | Value to scan |
| scan_rev | input | 1 | 0: lowest set bit first, 1: highest set bit first |
| size_wide | input | 1 | 0: scan bits 15:0, 1: scan bits 31:0 |
| prev_dest | input | 32 | Current destination value, returned unchanged on an all-zero scan |
| out_valid | output | 1 | Result fields are valid |
| dest | output | 32 | Found index, zero-extended, or prev_dest when nothing is found |
| dest_we | output | 1 | Destination should be written |
| zero_flag | output | 1 | Scanned bits were all zero |

## Verification
Size masking and the reverse mirror act in the same cycle. A reverse narrow scan of an operand whose only set bits lie in the upper half has to be seen as empty. It must not return an index near 31. Vectors such as 0xFFFF0000 and 0xFFFF0040 with scan_rev = 1 and size_wide = 0 provoke this. They are judged by whether the zero flag rises and prev_dest is passed through, or whether index 6 comes back. A second overlap is the all-zero bypass colliding with back-to-back requests. Consecutive valid inputs with different prev_dest values check that each result carries its own prev_dest.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic {
    DIR_LOW_FIRST  = 1'b0,
    DIR_HIGH_FIRST = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/bsu_front.sv
// Masks the operand to the selected size and mirrors it for a reverse scan,
// so that one lowest-first finder serves both directions.
module bsu_front #(
  parameter int W  = 32,
  parameter int NW = 16
) (
  input  logic [W-1:0] operand,
  input  logic         size_wide,
  input  logic         scan_rev,
  output logic [W-1:0] scan_vec
);
  logic [W-1:0] masked;
  logic [W-1:0] mirrored;

  assign masked = size_wide ? operand : {{(W-NW){1'b0}}, operand[NW-1:0]};

  for (genvar g = 0; g < W; g++) begin : g_mirror
    assign mirrored[g] = masked[W-1-g];
  end

  assign scan_vec = (scan_rev == bsu_pkg::DIR_HIGH_FIRST) ? mirrored : masked;
endmodule

// File: rtl/bsu_lowest_one.sv
// Priority finder: index of the lowest set bit plus a found indication.
module bsu_lowest_one #(
  parameter int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = i[IW-1:0];
    end
  end

  assign found = |vec;
endmodule

// File: rtl/bsu_result.sv
// Un-mirrors the index for reverse scans and selects the destination value.
module bsu_result #(
  parameter int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [IW-1:0] idx,
  input  logic          found,
  input  logic          scan_rev,
  input  logic [W-1:0]  prev_dest,
  output logic [W-1:0]  dest,
  output logic          dest_we,
  output logic          zero_flag
);
  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

  logic [IW-1:0] pos;

  assign pos       = (scan_rev == bsu_pkg::DIR_HIGH_FIRST) ? (TOP_IDX - idx) : idx;
  assign dest      = found ? {{(W-IW){1'b0}}, pos} : prev_dest;
  assign dest_we   = found;
  assign zero_flag = ~found;
endmodule

// File: rtl/bsu_out_stage.sv
// Optional output register; REG_OUT = 0 gives a pass-through.
module bsu_out_stage #(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_in,
  input  logic [W-1:0] d_in,
  input  logic         we_in,
  input  logic         zf_in,
  output logic         v_out,
  output logic [W-1:0] d_out,
  output logic         we_out,
  output logic         zf_out
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        v_out  <= 1'b0;
        d_out  <= '0;
        we_out <= 1'b0;
        zf_out <= 1'b0;
      end else begin
        v_out  <= v_in;
        d_out  <= d_in;
        we_out <= v_in & we_in;
        zf_out <= v_in & zf_in;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk;
    assign v_out  = v_in & ~rst;
    assign d_out  = rst ? '0 : d_in;
    assign we_out = v_in & we_in & ~rst;
    assign zf_out = v_in & zf_in & ~rst;
  end
endmodule

// File: rtl/bit_scan_unit.sv
module bit_scan_unit #(
  parameter int W       = 32,
  parameter int NW      = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int IW     = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] operand,
  input  logic         scan_rev,
  input  logic         size_wide,
  input  logic [W-1:0] prev_dest,
  output logic         out_valid,
  output logic [W-1:0] dest,
  output logic         dest_we,
  output logic         zero_flag
);
  logic [W-1:0]  scan_vec;
  logic [IW-1:0] low_idx;
  logic          any_set;
  logic [W-1:0]  res_dest;
  logic          res_we;
  logic          res_zf;

  bsu_front #(.W(W), .NW(NW)) front_i (
    .operand  (operand),
    .size_wide(size_wide),
    .scan_rev (scan_rev),
    .scan_vec (scan_vec)
  );

  bsu_lowest_one #(.W(W)) finder_i (
    .vec  (scan_vec),
    .idx  (low_idx),
    .found(any_set)
  );

  bsu_result #(.W(W)) result_i (
    .idx      (low_idx),
    .found    (any_set),
    .scan_rev (scan_rev),
    .prev_dest(prev_dest),
    .dest     (res_dest),
    .dest_we  (res_we),
    .zero_flag(res_zf)
  );

  bsu_out_stage #(.W(W), .REG_OUT(REG_OUT)) out_i (
    .clk   (clk),
    .rst   (rst),
    .v_in  (in_valid),
    .d_in  (res_dest),
    .we_in (res_we),
    .zf_in (res_zf),
    .v_out (out_valid),
    .d_out (dest),
    .we_out(dest_we),
    .zf_out(zero_flag)
  );
endmodule

// File: rtl/bit_scan_unit_chk.sv
module bit_scan_unit_chk #(
  parameter int W       = 32,
  parameter int NW      = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int IW     = $clog2(W)
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] operand,
  input logic         scan_rev,
  input logic         size_wide,
  input logic [W-1:0] prev_dest,
  input logic         out_valid,
  input logic [W-1:0] dest,
  input logic         dest_we,
  input logic         zero_flag
);
  // Input fields seen at the previous edge, held by the checker itself.
  logic [W-1:0] op_q;
  logic [W-1:0] prev_q;
  logic         rev_q;
  logic         wide_q;
  logic [W-1:0] eff_q;

  always_ff @(posedge clk) begin
    op_q   <= operand;
    prev_q <= prev_dest;
    rev_q  <= scan_rev;
    wide_q <= size_wide;
  end

  assign eff_q = wide_q ? op_q : {{(W-NW){1'b0}}, op_q[NW-1:0]};

  // R9
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!out_valid && !dest_we && !zero_flag));

  // R5
  we_vs_zf_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (dest_we != zero_flag));

  // R7
  zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !zero_flag) |-> (dest[W-1:IW] == '0));

  if (REG_OUT) begin : g_timed
    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    // R8
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    // R4
    keep_prev_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && zero_flag) |-> (dest == prev_q && !dest_we && eff_q == '0));
    // R3
    hit_is_set_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !zero_flag) |-> eff_q[dest[IW-1:0]]);
    // R1
    nothing_below_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !zero_flag && !rev_q) |->
        ((eff_q & ((W'(1) << dest[IW-1:0]) - W'(1))) == '0));
    // R2
    nothing_above_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !zero_flag && rev_q) |->
        (((eff_q >> dest[IW-1:0]) >> 1) == '0));
    // R6
    narrow_range_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !zero_flag && !wide_q) |-> (dest < W'(NW)));
  end
endmodule

bind bit_scan_unit bit_scan_unit_chk #(.W(W), .NW(NW), .REG_OUT(REG_OUT)) chk_i (.*);

// File: tb/bit_scan_unit_tb_top.sv
`timescale 1ns/1ps
module bit_scan_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] operand;
  logic        scan_rev;
  logic        size_wide;
  logic [31:0] prev_dest;
  logic        out_valid;
  logic [31:0] dest;
  logic        dest_we;
  logic        zero_flag;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bit_scan_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
    .scan_rev(scan_rev), .size_wide(size_wide), .prev_dest(prev_dest),
    .out_valid(out_valid), .dest(dest), .dest_we(dest_we), .zero_flag(zero_flag)
  );

  // Vector table: operand, direction, size, prev value, expected dest, expected zero flag.
  localparam int NV = 15;
  localparam logic [31:0] V_OP [NV] = '{
    32'h0000_0001, 32'h8000_0000, 32'h8000_0000, 32'h0000_0001, 32'h0012_3400,
    32'h0012_3400, 32'h0000_0000, 32'hFFFF_0000, 32'hFFFF_0000, 32'hFFFF_0040,
    32'h8001_8000, 32'h0001_8001, 32'h0001_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam logic V_REV [NV] = '{0,0,1,1,0, 1,0,0,1,1, 0,1,0,1,0};
  localparam logic V_WIDE [NV] = '{1,1,1,1,1, 1,1,0,0,0, 0,0,1,1,1};
  localparam logic [31:0] V_PREV [NV] = '{
    32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444, 32'h5555_5555,
    32'h6666_6666, 32'hDEAD_BEEF, 32'h1234_5678, 32'hCAFE_F00D, 32'h7777_7777,
    32'h8888_8888, 32'h9999_9999, 32'hAAAA_AAAA, 32'hBBBB_BBBB, 32'hCCCC_CCCC};
  localparam logic [31:0] V_EXP [NV] = '{
    32'd0, 32'd31, 32'd31, 32'd0, 32'd10,
    32'd20, 32'hDEAD_BEEF, 32'h1234_5678, 32'hCAFE_F00D, 32'd6,
    32'd15, 32'd15, 32'd16, 32'd31, 32'd0};
  localparam logic V_ZF [NV] = '{0,0,0,0,0, 0,1,1,1,0, 0,0,0,0,0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] op, input logic rev, input logic wide,
                       input logic [31:0] prev);
    in_valid  = 1'b1;
    operand   = op;
    scan_rev  = rev;
    size_wide = wide;
    prev_dest = prev;
  endtask

  task automatic idle();
    in_valid  = 1'b0;
    operand   = 32'h0;
    scan_rev  = 1'b0;
    size_wide = 1'b1;
    prev_dest = 32'h0;
  endtask

  task automatic check_result(input string tag, input logic [31:0] exp_d, input logic exp_zf);
    check({tag, " out_valid (R8)"}, {31'd0, out_valid}, 32'd1);
    check({tag, " dest"}, dest, exp_d);
    check({tag, " zero_flag (R3)"}, {31'd0, zero_flag}, {31'd0, exp_zf});
    check({tag, " dest_we (R5)"}, {31'd0, dest_we}, {31'd0, ~exp_zf});
  endtask

  initial begin
    rst = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 out_valid", {31'd0, out_valid}, 32'd0);
    check("R9 dest", dest, 32'd0);
    check("R9 dest_we", {31'd0, dest_we}, 32'd0);
    check("R9 zero_flag", {31'd0, zero_flag}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    // R8: idle input gives no valid output
    check("R8 idle", {31'd0, out_valid}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      string tag;
      drive(V_OP[k], V_REV[k], V_WIDE[k], V_PREV[k]);
      @(negedge clk);
      idle();
      if (V_ZF[k]) tag = "R4 zero keeps prev";
      else if (!V_WIDE[k]) tag = "R6 narrow scan";
      else if (V_REV[k]) tag = "R2 reverse";
      else tag = "R1 forward";
      check_result(tag, V_EXP[k], V_ZF[k]);
      if (!V_ZF[k]) check("R7 upper dest bits", {27'd0, dest[31:5]}, 32'd0);
      @(negedge clk);
      check("R8 single-cycle valid", {31'd0, out_valid}, 32'd0);
    end

    // R10: lone bit 9 gives 9 in both directions
    drive(32'h0000_0200, 1'b0, 1'b1, 32'h0);
    @(negedge clk);
    drive(32'h0000_0200, 1'b1, 1'b1, 32'h0);
    check_result("R10 lone bit fwd", 32'd9, 1'b0);
    @(negedge clk);
    // R4: back-to-back zero scans each carry their own prev value
    drive(32'h0000_0000, 1'b1, 1'b1, 32'hA5A5_0001);
    check_result("R10 lone bit rev", 32'd9, 1'b0);
    @(negedge clk);
    drive(32'hABCD_0000, 1'b0, 1'b0, 32'h5A5A_0002);
    check_result("R4 b2b first", 32'hA5A5_0001, 1'b1);
    @(negedge clk);
    // R6: same operand, wide size now finds bit 16
    drive(32'hABCD_0000, 1'b0, 1'b1, 32'h0);
    check_result("R4 b2b second", 32'h5A5A_0002, 1'b1);
    @(negedge clk);
    drive(32'hABCD_0000, 1'b1, 1'b1, 32'h0);
    check_result("R6 wide forward", 32'd16, 1'b0);
    @(negedge clk);
    idle();
    check_result("R2 wide reverse", 32'd31, 1'b0);

    // R9: reset while a request is pending clears outputs
    drive(32'h0000_0010, 1'b0, 1'b1, 32'h0);
    rst = 1'b1;
    @(negedge clk);
    idle();
    check("R9 mid-run valid", {31'd0, out_valid}, 32'd0);
    check("R9 mid-run dest", dest, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule